// File: doc/BRIEF.md
# Divider Configuration Port

This block is the configuration front end of a clock synthesizer. It holds three fields: a 3-bit test-select code, a 2-bit post-divider code and a 7-bit feedback-divider code. Downstream divider logic reads these fields. The fields can be written over two paths. A parallel path takes the feedback and post-divider codes straight from pins. A three-wire serial path (clock, data, load) builds a 12-bit word in a shift register and then moves it into the configuration registers.

Both strobes act as level-transparent gates. While the parallel strobe is low, the registers track the parallel pins and the test field is held at zero. The rising edge of that strobe freezes the values. While the serial load strobe is high, the registers track the shift register, and its falling edge freezes them. The parallel path wins: the serial load only takes effect while the parallel strobe is high.

The block runs in one system clock domain. Every external input passes through a synchronizer, and the serial clock is edge-detected. As a result, no real latches are built.

Top module: `divcfg_port`

## Requirements
- R1: While reset is asserted, the outputs are test = 000, post = 11 and feedback = 1111111, which are the all-ones pin defaults with the test field cleared.
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of a 12-bit register. Word bits 11:9 go to test, bits 8:7 go to post and bits 6:0 go to feedback. The first bit sent therefore lands in the test MSB and the last bit sent in the feedback LSB.
- R3: While the serial load strobe is high and the parallel strobe is high, the outputs follow the shift register, including shifts made during that time.
- R4: While both the serial load strobe and the parallel strobe are inactive (serial low, parallel high), the outputs hold. This holds even while the serial clock keeps shifting.
- R5: While the parallel strobe is low, feedback and post follow the parallel pins and test reads 000.
- R6: After the parallel strobe rises, feedback and post keep the last values taken while it was low, even if the pins change afterwards.
- R7: A serial load pulse given while the parallel strobe is low has no effect on the outputs.
- R8: After more than 12 serial shifts, only the last 12 bits sent are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, rising edge shifts |
| ser_din | input | 1 | Serial data, MSB of the test field first |
| ser_load | input | 1 | Serial load strobe, transparent high, captures on fall |
| par_load | input | 1 | Parallel load strobe, transparent low, captures on rise |
| par_fb | input | 7 | Parallel feedback-divider code |
| par_post | input | 2 | Parallel post-divider code |
| cfg_test | output | 3 | Test-select field |
| cfg_post | output | 2 | Post-divider field |
| cfg_fb | output | 7 | Feedback-divider field |

## Verification
A misplaced or stuck shift-register bit shows up as a wrong field value as soon as a load strobe opens. That is the synchronizer depth plus one system cycle after the strobe level reaches the pin. A broken priority or hold path shows up in the same window: an output changes while the other strobe is active, or while neither strobe is open. Known words are shifted in, each strobe is pulsed, and every field is compared after the pipeline has settled.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    localparam int TEST_W = 3;
    localparam int POST_W = 2;
    localparam int FB_W   = 7;
    localparam int WORD_W = TEST_W + POST_W + FB_W;

    // field order inside the serial word is behavioural: test is sent first
    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic [POST_W-1:0] post;
        logic [FB_W-1:0]   fb;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{test: '0, post: '1, fb: '1};

    function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.test = w[WORD_W-1 -: TEST_W];
        c.post = w[FB_W +: POST_W];
        c.fb   = w[FB_W-1:0];
        return c;
    endfunction

    function automatic cfg_t pins_to_cfg(input logic [POST_W-1:0] post,
                                         input logic [FB_W-1:0]   fb);
        cfg_t c;
        c.test = '0;
        c.post = post;
        c.fb   = fb;
        return c;
    endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_lvl,
    input  logic             sdin_lvl,
    output logic             shift_evt,
    output logic [WIDTH-1:0] word
);
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_lvl;
    end

    assign shift_evt = sclk_lvl & ~sclk_prev;

    always_ff @(posedge clk) begin
        if (rst)            word <= '0;
        else if (shift_evt) word <= {word[WIDTH-2:0], sdin_lvl};
    end
endmodule

// File: rtl/divcfg_latch.sv
module divcfg_latch
    import divcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_open,
    input  logic              ser_open,
    input  cfg_t              par_cfg,
    input  logic [WORD_W-1:0] ser_word,
    output cfg_t              cfg
);
    typedef enum logic [1:0] {SRC_HOLD, SRC_PAR, SRC_SER} src_e;
    src_e src;

    always_comb begin
        if (par_open)      src = SRC_PAR;
        else if (ser_open) src = SRC_SER;
        else               src = SRC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_DEFAULT;
        end else begin
            case (src)
                SRC_PAR: cfg <= par_cfg;
                SRC_SER: cfg <= word_to_cfg(ser_word);
                default: cfg <= cfg;
            endcase
        end
    end
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_load,
    input  logic              par_load,
    input  logic [FB_W-1:0]   par_fb,
    input  logic [POST_W-1:0] par_post,
    output logic [TEST_W-1:0] cfg_test,
    output logic [POST_W-1:0] cfg_post,
    output logic [FB_W-1:0]   cfg_fb
);
    localparam int CTL_W = 4;
    localparam int PIN_W = POST_W + FB_W;

    logic [CTL_W-1:0] ctl_q;
    logic [PIN_W-1:0] pin_q;
    logic             sclk_lvl, sdin_lvl, sload_lvl, pload_lvl;
    logic             par_open, ser_open, shift_evt;
    logic [WORD_W-1:0] ser_word;
    cfg_t             par_cfg, cfg;

    divcfg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ctl_sync (
        .clk(clk), .rst(rst),
        .d({par_load, ser_load, ser_din, ser_clk}),
        .q(ctl_q)
    );

    divcfg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
        .clk(clk), .rst(rst),
        .d({par_post, par_fb}),
        .q(pin_q)
    );

    assign {pload_lvl, sload_lvl, sdin_lvl, sclk_lvl} = ctl_q;
    assign par_open = ~pload_lvl;
    assign ser_open = sload_lvl;
    assign par_cfg  = pins_to_cfg(pin_q[FB_W +: POST_W], pin_q[FB_W-1:0]);

    divcfg_shreg #(.WIDTH(WORD_W)) u_shreg (
        .clk(clk), .rst(rst),
        .sclk_lvl(sclk_lvl), .sdin_lvl(sdin_lvl),
        .shift_evt(shift_evt), .word(ser_word)
    );

    divcfg_latch u_latch (
        .clk(clk), .rst(rst),
        .par_open(par_open), .ser_open(ser_open),
        .par_cfg(par_cfg), .ser_word(ser_word),
        .cfg(cfg)
    );

    assign cfg_test = cfg.test;
    assign cfg_post = cfg.post;
    assign cfg_fb   = cfg.fb;
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
    import divcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              par_open,
    input logic              ser_open,
    input logic              shift_evt,
    input logic              sdin_lvl,
    input logic [WORD_W-1:0] ser_word,
    input logic [PIN_SUM-1:0] pin_q,
    input logic [TEST_W-1:0] cfg_test,
    input logic [POST_W-1:0] cfg_post,
    input logic [FB_W-1:0]   cfg_fb
);
    localparam int PIN_SUM = POST_W + FB_W;

    AST_SHIFT_INSERTS_LSB: assert property (@(posedge clk) disable iff (rst)
        shift_evt |=> (ser_word == {$past(ser_word[WORD_W-2:0]), $past(sdin_lvl)})); // R2

    AST_SER_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (!par_open && ser_open) |=> ({cfg_test, cfg_post, cfg_fb} == $past(ser_word))); // R3

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!par_open && !ser_open) |=> $stable({cfg_test, cfg_post, cfg_fb})); // R4

    AST_PAR_TEST_ZERO: assert property (@(posedge clk) disable iff (rst)
        par_open |=> (cfg_test == '0)); // R5

    AST_PAR_OVERRIDES_SER: assert property (@(posedge clk) disable iff (rst)
        (par_open && ser_open) |=> ({cfg_post, cfg_fb} == $past(pin_q))); // R7
endmodule

bind divcfg_port divcfg_chk u_chk (
    .clk(clk), .rst(rst),
    .par_open(par_open), .ser_open(ser_open),
    .shift_evt(shift_evt), .sdin_lvl(sdin_lvl),
    .ser_word(ser_word), .pin_q(pin_q),
    .cfg_test(cfg_test), .cfg_post(cfg_post), .cfg_fb(cfg_fb)
);

// File: tb/divcfg_port_tb.sv
module divcfg_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0, par_load = 1'b0;
    logic [6:0] par_fb = '1;
    logic [1:0] par_post = '1;
    logic [2:0] cfg_test;
    logic [1:0] cfg_post;
    logic [6:0] cfg_fb;

    always #10 clk = ~clk;

    divcfg_port u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .par_load(par_load), .par_fb(par_fb),
        .par_post(par_post), .cfg_test(cfg_test), .cfg_post(cfg_post),
        .cfg_fb(cfg_fb)
    );

    typedef struct {
        string       req;
        logic [11:0] exp;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0, n_fail = 0;
    logic [11:0] model_sr = '0;
    bit          done = 0;

    // monitor: pops expected items and compares them away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [11:0] act;
                it  = sb_q.pop_front();
                act = {cfg_test, cfg_post, cfg_fb};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%03h expected=%03h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_cfg(input string req, input logic [11:0] exp);
        item_t it;
        idle(8);
        @(posedge clk);
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_din = b;
        idle(4);
        ser_clk = 1'b1;
        idle(4);
        ser_clk = 1'b0;
        idle(4);
        model_sr = {model_sr[10:0], b};
    endtask

    task automatic shift_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_sload();
        ser_load = 1'b1;
        idle(6);
        ser_load = 1'b0;
        idle(6);
    endtask

    localparam logic [11:0] W1 = {3'b101, 2'b01, 7'b1100110};
    localparam logic [11:0] W2 = {3'b011, 2'b10, 7'b0011001};
    localparam logic [11:0] W3 = {3'b110, 2'b00, 7'b1010101};

    initial begin
        logic [11:0] held;
        idle(4);
        expect_cfg("R1 reset defaults", {3'b000, 2'b11, 7'h7F});
        rst = 1'b0;

        par_fb = 7'h30; par_post = 2'b00;
        expect_cfg("R5 parallel follow", {3'b000, 2'b00, 7'h30});
        par_fb = 7'h55; par_post = 2'b10;
        expect_cfg("R5 parallel follow change", {3'b000, 2'b10, 7'h55});

        par_load = 1'b1;
        idle(6);
        par_fb = 7'h0F; par_post = 2'b01;
        expect_cfg("R6 hold after parallel rise", {3'b000, 2'b10, 7'h55});

        shift_word(W1);
        expect_cfg("R4 shifting without load", {3'b000, 2'b10, 7'h55});
        pulse_sload();
        expect_cfg("R2 field placement W1", W1);

        ser_load = 1'b1;
        shift_bit(1'b1);
        expect_cfg("R3 transparent while serial load high", model_sr);
        ser_load = 1'b0;
        held = model_sr;
        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
        expect_cfg("R4 hold after serial load falls", held);

        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        shift_word(W2);
        pulse_sload();
        expect_cfg("R8 last twelve bits kept", W2);

        par_load = 1'b0;
        par_fb = 7'h11; par_post = 2'b11;
        expect_cfg("R5 test forced zero on parallel low", {3'b000, 2'b11, 7'h11});
        shift_word(W3);
        pulse_sload();
        expect_cfg("R7 serial load ignored while parallel low", {3'b000, 2'b11, 7'h11});
        par_load = 1'b1;
        idle(6);
        expect_cfg("R6 parallel capture kept", {3'b000, 2'b11, 7'h11});
        pulse_sload();
        expect_cfg("R2 serial load after parallel release", W3);
        par_load = 1'b0;
        expect_cfg("R5 test cleared from nonzero", {3'b000, 2'b11, 7'h11});

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule